// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer

An 8-bit counter shared by three operating modes. In interval mode the count restarts at zero each time it equals the data value, and a square wave toggles on every restart. In capture mode a chosen edge on an external pin copies the running count into the data register, so software can time external events. In PWM mode the count runs freely from 00h to FFh and the output is high only while the count is above a compare value.

The count advances on an enable tick. A prescaler divides the clock by (prescale + 1), and a power-of-two divider of 2, 4, 8 or 16 follows it. A simple write port programs the block. Single-cycle pulses report match and overflow events, and each event also sets a sticky flag. A DMA request can ask for a new data value after every match.

Register map, selected by `wr_addr`:
- 0 is control: bit0 run, bits[2:1] mode, bit3 falling-edge capture, bits[6:4] DMA field.
- 1 is the prescale value.
- 2 is the data value.
- 3 is the divider select, bits[1:0].
- 4 clears the sticky flags on a write of 1: bit0 clears match, bit1 clears overflow.

Top module: `mode_timer8`

## Requirements
- R1: With run set, the count steps once every (P+1)·2^(S+1) clocks, where P is the prescale value and S is the divider select. Two ticks are never closer together than 2 clocks.
- R2: Interval mode is mode code 00 (code 11 behaves the same). When a tick finds the count equal to the data value, the count goes to 0, `tmr_out` toggles and `irq_match` pulses. The pulse period is therefore (data+1) ticks.
- R3: Capture mode is mode code 01. The pin passes through two synchronising flops. A rising edge, or a falling edge when control bit3 is 1, loads the running count into the data register 3 clocks after the pin changes. The opposite edge changes nothing. A write to the data register in the same cycle takes priority over a capture.
- R4: In capture and PWM modes, a tick at count FFh wraps the count to 00h and pulses `irq_ovf`.
- R5: PWM mode is mode code 10. `tmr_out` is low while the count is at or below the compare value and high while the count is above it. One period is 256 ticks. A tick that finds the count equal to the compare value pulses `irq_match` without clearing the count.
- R6: In PWM mode a write to the data register does not change the compare value until the next overflow. The compare value then takes the new data value. Outside PWM mode the compare value follows the data value.
- R7: With run cleared, the count, prescaler and divider stay at 0 and `tmr_out` is low. Setting run starts counting from 00h.
- R8: `irq_match` and `irq_ovf` are one-clock pulses. Each pulse sets its sticky flag. The flag stays set until a write of 1 to its clear bit at address 4. If a new event arrives in the same cycle as the clear, the flag stays set.
- R9: When the DMA field is 010, every match raises `dma_req`. The request stays high until the next write to the data register. If a match and a data write fall in the same cycle, the request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write value |
| cap_in | input | 1 | Capture pin, asynchronous |
| tmr_out | output | 1 | Toggle or PWM output |
| irq_match | output | 1 | Match event pulse |
| irq_ovf | output | 1 | Overflow event pulse |
| sts_match | output | 1 | Sticky match flag |
| sts_ovf | output | 1 | Sticky overflow flag |
| dma_req | output | 1 | Request for a new data value |
| count_val | output | 8 | Current count |
| data_val | output | 8 | Data register (written or captured) |

## Verification
The hardest case to reach is a data write in PWM mode that lands in the middle of a period: the compare value must hold until the wrap. The stimulus waits for an overflow pulse, writes a new value on that same cycle, and counts high cycles over the next two full periods. The first period must still show the old duty and the second the new one. A cycle-level reference model runs next to the directed cases. It covers random mode, prescale, divider and edge changes made while the timer runs, including prescale values lowered below the current prescaler count.

// File: rtl/mt8_pkg.sv
package mt8_pkg;

   typedef enum logic [1:0] {
      MD_INTERVAL = 2'd0,
      MD_CAPTURE  = 2'd1,
      MD_PWM      = 2'd2,
      MD_SPARE    = 2'd3
   } mt8_mode_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
   localparam logic [ADDR_W-1:0] A_DATA  = 3'd2;
   localparam logic [ADDR_W-1:0] A_DIV   = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_MODE = 1;
   localparam int unsigned CB_FALL = 3;
   localparam int unsigned CB_DMA  = 4;
   localparam int unsigned CTRL_W  = 7;

   localparam logic [2:0] DMA_ON = 3'b010;

endpackage

// File: rtl/mt8_tick_gen.sv
module mt8_tick_gen #(
   parameter int unsigned PRE_W = 8,
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre_lim,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);
   localparam int unsigned DIV_W = 1 << SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("mt8_tick_gen: SEL_W must be 1..3");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("mt8_tick_gen: PRE_W must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_mask;
   logic             pre_wrap;

   always_comb begin
      for (int i = 0; i < int'(DIV_W); i++) begin
         div_mask[i] = (i <= int'(div_sel));
      end
   end

   assign pre_wrap = run && (pre_cnt == pre_lim);
   assign tick     = pre_wrap && ((div_cnt & div_mask) == div_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
         if (pre_wrap) begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   // the smallest divider is 2, so two ticks never sit back to back
   assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_cnt == '0) && (div_cnt == '0));

endmodule

// File: rtl/mt8_edge_sync.sv
module mt8_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic hit
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mt8_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-1:0], pin};
      end
   end

   assign hit = fall_sel ? (!chain[STAGES-1] &&  chain[STAGES])
                         : ( chain[STAGES-1] && !chain[STAGES]);

   assert_hit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (!hit || (fall_sel != $past(fall_sel))));

endmodule

// File: rtl/mt8_count_core.sv
module mt8_count_core
   import mt8_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  mt8_mode_e        mode,
   input  logic [CNT_W-1:0] int_lim,
   input  logic [CNT_W-1:0] pwm_lim,
   output logic [CNT_W-1:0] cnt,
   output logic             tog,
   output logic             match_ev,
   output logic             ovf_ev
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("mt8_count_core: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nxt;
   logic             at_top;
   logic             hit_int;
   logic             hit_pwm;
   logic             free_run;

   assign at_top  = (cnt == CNT_TOP);
   assign hit_int = (cnt == int_lim);
   assign hit_pwm = (cnt == pwm_lim);

   always_comb begin
      match_ev = 1'b0;
      ovf_ev   = 1'b0;
      free_run = 1'b1;
      cnt_nxt  = cnt + 1'b1;
      unique case (mode)
         MD_CAPTURE: begin
            ovf_ev = tick && at_top;
         end
         MD_PWM: begin
            match_ev = tick && hit_pwm;
            ovf_ev   = tick && at_top;
         end
         default: begin
            free_run = 1'b0;
            match_ev = tick && hit_int;
            if (hit_int) begin
               cnt_nxt = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (tick) begin
         cnt <= cnt_nxt;
         if (match_ev && !free_run) begin
            tog <= !tog;
         end
      end
   end

   assert_int_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (match_ev && !free_run) |=> (cnt == '0));

   assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |=> (cnt == '0));

   assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0) && !tog);

endmodule

// File: rtl/mode_timer8.sv
module mode_timer8
   import mt8_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PRE_W       = 8,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              cap_in,
   output logic              tmr_out,
   output logic              irq_match,
   output logic              irq_ovf,
   output logic              sts_match,
   output logic              sts_ovf,
   output logic              dma_req,
   output logic [CNT_W-1:0]  count_val,
   output logic [CNT_W-1:0]  data_val
);
   generate
      if (REG_W < CNT_W || REG_W < PRE_W || REG_W < CTRL_W) begin : g_bad_reg
         $error("mode_timer8: REG_W too narrow for its fields");
      end
   endgenerate

   // control and configuration
   logic             ctl_run;
   mt8_mode_e        ctl_mode;
   logic             ctl_fall;
   logic [2:0]       ctl_dma;
   logic [PRE_W-1:0] pre_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] data_q;
   logic [CNT_W-1:0] cmp_q;

   logic wr_ctrl, wr_pre, wr_dat, wr_div, wr_clr;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_pre  = wr_en && (wr_addr == A_PRESC);
   assign wr_dat  = wr_en && (wr_addr == A_DATA);
   assign wr_div  = wr_en && (wr_addr == A_DIV);
   assign wr_clr  = wr_en && (wr_addr == A_STAT);

   // datapath
   logic             tick;
   logic             cap_hit;
   logic [CNT_W-1:0] cnt;
   logic             tog;
   logic             match_ev;
   logic             ovf_ev;
   logic             pwm_on;

   assign pwm_on = ctl_run && (ctl_mode == MD_PWM);

   mt8_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_run),
      .pre_lim (pre_q),
      .div_sel (sel_q),
      .tick    (tick)
   );

   mt8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_in),
      .fall_sel (ctl_fall),
      .hit      (cap_hit)
   );

   mt8_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctl_run),
      .tick     (tick),
      .mode     (ctl_mode),
      .int_lim  (data_q),
      .pwm_lim  (cmp_q),
      .cnt      (cnt),
      .tog      (tog),
      .match_ev (match_ev),
      .ovf_ev   (ovf_ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_run  <= 1'b0;
         ctl_mode <= MD_INTERVAL;
         ctl_fall <= 1'b0;
         ctl_dma  <= '0;
         pre_q    <= '0;
         sel_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            ctl_run  <= wr_data[CB_RUN];
            ctl_mode <= mt8_mode_e'(wr_data[CB_MODE +: 2]);
            ctl_fall <= wr_data[CB_FALL];
            ctl_dma  <= wr_data[CB_DMA +: 3];
         end
         if (wr_pre) begin
            pre_q <= wr_data[PRE_W-1:0];
         end
         if (wr_div) begin
            sel_q <= wr_data[SEL_W-1:0];
         end
      end
   end

   // data register: software write wins over a capture in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_dat) begin
         data_q <= wr_data[CNT_W-1:0];
      end else if (ctl_run && (ctl_mode == MD_CAPTURE) && cap_hit) begin
         data_q <= cnt;
      end
   end

   // compare buffer: follows data except inside a running PWM period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (!pwm_on || ovf_ev) begin
         cmp_q <= data_q;
      end
   end

   // event pulses, sticky flags and reload request
   logic irq_m_q, irq_o_q, st_m_q, st_o_q, dreq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_m_q <= 1'b0;
         irq_o_q <= 1'b0;
         st_m_q  <= 1'b0;
         st_o_q  <= 1'b0;
         dreq_q  <= 1'b0;
      end else begin
         irq_m_q <= match_ev;
         irq_o_q <= ovf_ev;
         st_m_q  <= (st_m_q && !(wr_clr && wr_data[0])) || match_ev;
         st_o_q  <= (st_o_q && !(wr_clr && wr_data[1])) || ovf_ev;
         if (match_ev && (ctl_dma == DMA_ON)) begin
            dreq_q <= 1'b1;
         end else if (wr_dat) begin
            dreq_q <= 1'b0;
         end
      end
   end

   assign tmr_out   = ctl_run && ((ctl_mode == MD_PWM) ? (cnt > cmp_q) : tog);
   assign irq_match = irq_m_q;
   assign irq_ovf   = irq_o_q;
   assign sts_match = st_m_q;
   assign sts_ovf   = st_o_q;
   assign dma_req   = dreq_q;
   assign count_val = cnt;
   assign data_val  = data_q;

   assert_pwm_low_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && (cnt == '0)) |-> !tmr_out);

   assert_cmp_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && $past(pwm_on) && !$past(ovf_ev)) |-> $stable(cmp_q));

   assert_match_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_m_q |=> !irq_m_q);

   assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o_q |=> !irq_o_q);

   assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_m_q && !(wr_clr && wr_data[0])) |=> st_m_q);

   assert_dma_from_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dreq_q) |-> irq_m_q);

   assert_dma_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_q && !wr_dat) |=> dreq_q);

endmodule

// File: tb/mode_timer8_bench.sv
module mode_timer8_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       cap_in = 1'b0;
   logic       tmr_out, irq_match, irq_ovf, sts_match, sts_ovf, dma_req;
   logic [7:0] count_val, data_val;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = !clk;

   mode_timer8 u_mode_timer8 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cap_in    (cap_in),
      .tmr_out   (tmr_out),
      .irq_match (irq_match),
      .irq_ovf   (irq_ovf),
      .sts_match (sts_match),
      .sts_ovf   (sts_ovf),
      .dma_req   (dma_req),
      .count_val (count_val),
      .data_val  (data_val)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int tick_period(input int pre, input int sel);
      return (pre + 1) * (2 << sel);
   endfunction

   function automatic int pwm_high_cycles(input int cmp, input int per);
      return (255 - cmp) * per;
   endfunction

   // ---------------- cycle-level reference model ----------------
   int m_en, m_mode, m_fall, m_dma, m_pre, m_sel, m_data, m_cmp;
   int m_pc, m_dc, m_cnt, m_tog, m_im, m_io, m_sm, m_so, m_dq;
   int m_s1, m_s2, m_s3;

   always @(posedge clk) begin : model
      int tk, msk, hit, mt, ov, n_cnt, n_tog, n_data, n_cmp, n_pc, n_dc;
      if (!rst_n) begin
         m_en = 0; m_mode = 0; m_fall = 0; m_dma = 0; m_pre = 0; m_sel = 0;
         m_data = 0; m_cmp = 0; m_pc = 0; m_dc = 0; m_cnt = 0; m_tog = 0;
         m_im = 0; m_io = 0; m_sm = 0; m_so = 0; m_dq = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         msk = (2 << m_sel) - 1;
         tk  = (m_en != 0 && m_pc == m_pre && (m_dc & msk) == msk) ? 1 : 0;
         hit = (m_fall != 0) ? ((m_s2 == 0 && m_s3 == 1) ? 1 : 0)
                             : ((m_s2 == 1 && m_s3 == 0) ? 1 : 0);
         mt = 0; ov = 0; n_cnt = m_cnt; n_tog = m_tog;
         if (m_en == 0) begin
            n_cnt = 0; n_tog = 0;
         end else if (tk != 0) begin
            if (m_mode == 1) begin
               ov = (m_cnt == 255) ? 1 : 0;
               n_cnt = (m_cnt + 1) % 256;
            end else if (m_mode == 2) begin
               mt = (m_cnt == m_cmp) ? 1 : 0;
               ov = (m_cnt == 255) ? 1 : 0;
               n_cnt = (m_cnt + 1) % 256;
            end else if (m_cnt == m_data) begin
               mt = 1; n_cnt = 0; n_tog = 1 - m_tog;
            end else begin
               n_cnt = (m_cnt + 1) % 256;
            end
         end
         n_pc = m_pc; n_dc = m_dc;
         if (m_en == 0) begin
            n_pc = 0; n_dc = 0;
         end else if (m_pc == m_pre) begin
            n_pc = 0; n_dc = (m_dc + 1) % 16;
         end else begin
            n_pc = (m_pc + 1) % 256;
         end
         n_cmp = m_cmp;
         if (m_en == 0 || m_mode != 2 || ov != 0) n_cmp = m_data;
         n_data = m_data;
         if (wr_en && wr_addr == 3'd2) n_data = int'(wr_data);
         else if (m_en != 0 && m_mode == 1 && hit != 0) n_data = m_cnt;
         if (mt != 0 && m_dma == 2) m_dq = 1;
         else if (wr_en && wr_addr == 3'd2) m_dq = 0;
         m_sm = ((m_sm != 0 && !(wr_en && wr_addr == 3'd4 && wr_data[0])) || mt != 0) ? 1 : 0;
         m_so = ((m_so != 0 && !(wr_en && wr_addr == 3'd4 && wr_data[1])) || ov != 0) ? 1 : 0;
         m_im = mt; m_io = ov;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(cap_in);
         m_cnt = n_cnt; m_tog = n_tog; m_pc = n_pc; m_dc = n_dc;
         m_cmp = n_cmp; m_data = n_data;
         if (wr_en && wr_addr == 3'd0) begin
            m_en = int'(wr_data[0]); m_mode = int'(wr_data[2:1]);
            m_fall = int'(wr_data[3]); m_dma = int'(wr_data[6:4]);
         end
         if (wr_en && wr_addr == 3'd1) m_pre = int'(wr_data);
         if (wr_en && wr_addr == 3'd3) m_sel = int'(wr_data[1:0]);
      end
   end

   // compare every cycle once reset is released
   always @(negedge clk) begin
      int e_out;
      if (rst_n) begin
         e_out = (m_en == 0) ? 0 : ((m_mode == 2) ? ((m_cnt > m_cmp) ? 1 : 0) : m_tog);
         chk("R1", "model count", int'(count_val), m_cnt);
         chk("R3", "model data", int'(data_val), m_data);
         chk("R5", "model tmr_out", int'(tmr_out), e_out);
         chk("R2", "model irq_match", int'(irq_match), m_im);
         chk("R4", "model irq_ovf", int'(irq_ovf), m_io);
         chk("R8", "model sts_match", int'(sts_match), m_sm);
         chk("R8", "model sts_ovf", int'(sts_ovf), m_so);
         chk("R9", "model dma_req", int'(dma_req), m_dq);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input bit ovf, input int limit, input string req);
      int n = 0;
      while ((ovf ? irq_ovf : irq_match) !== 1'b1 && n < limit) begin
         @(negedge clk);
         n++;
      end
      chk(req, "event seen before timeout", (n < limit) ? 1 : 0, 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int per, n, o1, c, h;
      void'($urandom(32'h1A2B3C4D));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7", "reset count", int'(count_val), 0);
      chk("R7", "reset tmr_out", int'(tmr_out), 0);
      chk("R8", "reset irq/sts", int'({irq_match, irq_ovf, sts_match, sts_ovf}), 0);
      chk("R9", "reset dma_req", int'(dma_req), 0);

      // interval mode, DMA field 010, prescale 1, divide by 2
      wr(3'd3, 8'd0);
      wr(3'd1, 8'd1);
      wr(3'd2, 8'd5);
      wr(3'd0, 8'h21);
      per = tick_period(1, 0);
      wait_irq(1'b0, 400, "R2");
      o1 = int'(tmr_out);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (irq_match !== 1'b1 && n < 400);
      chk("R2", "match spacing", n, 6 * per);
      chk("R1", "tick rate via match spacing", n / 6, per);
      chk("R2", "count cleared on match", int'(count_val), 0);
      chk("R2", "output toggled", int'(tmr_out), 1 - o1);
      chk("R9", "dma_req raised by match", int'(dma_req), 1);
      @(negedge clk);
      chk("R8", "match pulse one cycle", int'(irq_match), 0);
      chk("R8", "sticky match set", int'(sts_match), 1);
      repeat (2) @(negedge clk);
      chk("R9", "dma_req held", int'(dma_req), 1);
      wr(3'd4, 8'h01);
      chk("R8", "sticky match cleared", int'(sts_match), 0);
      wr(3'd2, 8'd5);
      chk("R9", "dma_req released by data write", int'(dma_req), 0);

      // disable and re-enable
      wr(3'd0, 8'h00);
      @(negedge clk);
      chk("R7", "disabled count", int'(count_val), 0);
      chk("R7", "disabled output", int'(tmr_out), 0);
      wr(3'd0, 8'h01);
      chk("R7", "count starts at 0", int'(count_val), 0);

      // capture mode, 20 clocks per tick
      wr(3'd1, 8'd9);
      wr(3'd0, 8'h03);
      repeat (45) @(negedge clk);
      cap_in = 1'b1;
      repeat (2) @(negedge clk);
      c = int'(count_val);
      @(negedge clk);
      chk("R3", "rising edge capture", int'(data_val), c);
      repeat (30) @(negedge clk);
      cap_in = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3", "falling edge ignored", int'(data_val), c);
      wr(3'd0, 8'h0B);
      repeat (30) @(negedge clk);
      cap_in = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3", "rising edge ignored in fall mode", int'(data_val), c);
      repeat (25) @(negedge clk);
      cap_in = 1'b0;
      repeat (2) @(negedge clk);
      c = int'(count_val);
      @(negedge clk);
      chk("R3", "falling edge capture", int'(data_val), c);
      wait_irq(1'b1, 6000, "R4");
      chk("R4", "count wrapped to 0", int'(count_val), 0);
      chk("R8", "sticky overflow set", int'(sts_ovf), 1);

      // PWM mode, 2 clocks per tick, compare 0x40
      wr(3'd1, 8'd0);
      wr(3'd2, 8'h40);
      wr(3'd0, 8'h05);
      per = tick_period(0, 0);
      wait_irq(1'b1, 1200, "R4");
      h = 0;
      for (int i = 0; i < 256 * per; i++) begin
         if (tmr_out) h++;
         @(negedge clk);
      end
      chk("R5", "PWM high cycles, compare 0x40", h, pwm_high_cycles(64, per));
      chk("R4", "PWM overflow after 256 ticks", int'(irq_ovf), 1);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hC0;
      h = 0;
      for (int i = 0; i < 256 * per; i++) begin
         if (tmr_out) h++;
         @(negedge clk);
         wr_en = 1'b0;
      end
      chk("R6", "shadowed write keeps old duty", h, pwm_high_cycles(64, per));
      h = 0;
      for (int i = 0; i < 256 * per; i++) begin
         if (tmr_out) h++;
         @(negedge clk);
      end
      chk("R6", "new duty after overflow", h, pwm_high_cycles(192, per));
      chk("R5", "PWM match pulse seen", int'(sts_match), 1);

      // constrained random phase, checked by the reference model
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [7:0] v;
         op = $urandom_range(0, 9);
         case (op)
            0, 1: begin
               v = {1'b0, ($urandom_range(0, 1) != 0) ? 3'b010 : 3'($urandom),
                    1'($urandom), 2'($urandom), ($urandom_range(0, 9) != 0)};
               wr(3'd0, v);
            end
            2: wr(3'd1, 8'($urandom_range(0, 3)));
            3: wr(3'd3, 8'($urandom_range(0, 3)));
            4, 5: wr(3'd2, 8'($urandom));
            6: wr(3'd4, 8'($urandom_range(0, 3)));
            default: cap_in = !cap_in;
         endcase
         repeat ($urandom_range(5, 60)) @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule